// File: doc/BRIEF.md
# Banked Card Slot Status Controller

This block is the register side of a multi-slot smart card interface. A host reaches it over a byte-wide slave bus made of an address, read and write strobes, write data, read data and an acknowledge flag. A select register picks one of several banks: the general bank, or the bank of one card slot. The general bank holds a fixed version byte and an interrupt summary with one pending bit per slot. Each slot bank has a single port. Reading the port returns the card presence level, a sticky presence-change flag and a sticky supply-event flag. Writing the port sets the slot's control outputs: start, supply level, warm reset and I/O enable.

An active-low interrupt line goes low whenever a slot has an unread event, or when an external interrupt input from an auxiliary reader is low. While the shutdown input is low the block stops acknowledging the bus, but it keeps watching the card presence inputs and still pulls the interrupt line low on an insertion. When shutdown is released, the block holds an internal reset for a fixed number of cycles with the interrupt line released high. It then comes back in its power-up state, with every slot's supply flag pending.

Top module: `card_slot_ctrl`

## Requirements
- R1: Three addresses are decoded: bank select at 48h, bank port at 40h and interrupt summary at 42h. With `addr_strap` high they move to 4Ch, 44h and 46h. A decoded access is acknowledged one cycle after its strobe, and read data is valid alongside the acknowledge. Any other address gets no acknowledge.
- R2: The bank select register reads back the last byte written. A value of 00h selects the general bank, and values 01h to 05h select slots 1 to 5.
- R3: With the general bank selected, a read of the bank port returns C1h.
- R4: In the general bank, the summary byte carries bit n-1 set while slot n has an unread flag. It reads 1Fh after reset.
- R5: The slot status byte has bit 0 for card presence (taken after a two-flop synchronizer), bit 1 for presence changed (latched on either edge of bit 0) and bit 3 for the supply event (set by reset). All other bits read 0.
- R6: A read of a slot's status port clears that slot's presence-changed and supply flags. Flags in the other slots are left untouched.
- R7: A write to a slot port sets the slot's start output from bit 0, its 5 V select output from bit 2 (1 = 5 V, 0 = 3 V) and its I/O enable output from bit 6. Writing 05h leaves start and 5 V select high and I/O enable low.
- R8: Writing bit 1 of a slot port raises that slot's warm-reset output for exactly one cycle, beginning the cycle after the write.
- R9: `irq_n` is low while any slot flag is pending or `aux_irq_n` is low. Otherwise it is high, and it is high during reset.
- R10: While `shutdown_n` is low, no access is acknowledged. A presence change in that state still drives `irq_n` low.
- R11: After `shutdown_n` rises, `irq_n` is held high for WAKE_CYCLES cycles of internal reset. The block then returns to its power-up state: summary 1Fh, control outputs low and select 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strap | input | 1 | Address strap; high moves the three decoded addresses up by 4 |
| bus_addr | input | 8 | Access address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid with the acknowledge |
| bus_ack | output | 1 | Access acknowledge |
| card_present | input | NUM_SLOTS | Raw presence level per slot, high = card in |
| aux_irq_n | input | 1 | External interrupt request, active low |
| shutdown_n | input | 1 | Low puts the block in shutdown |
| irq_n | output | 1 | Interrupt request, active low |
| slot_start | output | NUM_SLOTS | Per-slot start/activate control |
| slot_5v | output | NUM_SLOTS | Per-slot supply select, high = 5 V |
| slot_ioen | output | NUM_SLOTS | Per-slot I/O enable |
| slot_warm | output | NUM_SLOTS | Per-slot one-cycle warm reset pulse |

## Verification
The case that is hardest to reach from the ports is a card insertion during shutdown, followed by the wake-up internal reset. The bus is deaf in that state, so the only evidence is the interrupt line: low while asleep, high for the reset window, then low again from the restored supply flags. The stimulus first clears every power-up flag one slot at a time, so that `irq_n` is high before shutdown. It then inserts a card while asleep and raises `shutdown_n`. After wake-up, the summary byte and the inserted slot's status confirm that the change flag was dropped and the supply flag came back.

// File: rtl/card_slot_pkg.sv
`timescale 1ns/1ps
// Shared constants for the banked card slot controller.
// Assumes at most eight slots so the pending summary fits one byte.
package card_slot_pkg;
    localparam logic [7:0] SEL_ADDR     = 8'h48;
    localparam logic [7:0] PORT_ADDR    = 8'h40;
    localparam logic [7:0] SUMMARY_ADDR = 8'h42;
    localparam logic [7:0] STRAP_OFFSET = 8'h04;
    localparam logic [7:0] VERSION_BYTE = 8'hC1;
    localparam int unsigned CTL_START = 0;
    localparam int unsigned CTL_WARM  = 1;
    localparam int unsigned CTL_5V    = 2;
    localparam int unsigned CTL_IOEN  = 6;
endpackage

// File: rtl/slot_presence_sync.sv
`timescale 1ns/1ps
// Synchronizes raw card presence levels with two flops per slot and flags
// any edge of the synchronized level. Assumes raw inputs are asynchronous.
module slot_presence_sync #(
    parameter int unsigned NUM_SLOTS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] raw_present,
    output logic [NUM_SLOTS-1:0] present_lvl,
    output logic [NUM_SLOTS-1:0] present_chg
);
    logic [NUM_SLOTS-1:0] meta_q;
    logic [NUM_SLOTS-1:0] sync_q;
    logic [NUM_SLOTS-1:0] prev_q;

    // Two-stage synchronizer plus history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_present;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Level is the synchronized value; a change is any mismatch with history.
    always_comb begin
        present_lvl = sync_q;
        present_chg = sync_q ^ prev_q;
    end
endmodule

// File: rtl/slot_status_reg.sv
`timescale 1ns/1ps
// One slot's status/control register: sticky change and supply flags that
// clear on read, plus control outputs loaded by writes. The warm reset is a
// single-cycle pulse. A synchronous clear restores the power-up state.
module slot_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_clear,
    input  logic       pres_lvl,
    input  logic       pres_chg,
    input  logic       wr_en,
    input  logic       wr_start,
    input  logic       wr_warm,
    input  logic       wr_5v,
    input  logic       wr_ioen,
    input  logic       rd_clear,
    output logic [7:0] status,
    output logic       pending,
    output logic       start,
    output logic       sel_5v,
    output logic       ioen,
    output logic       warm
);
    logic chg_flag_q;
    logic supply_flag_q;

    // Flag and control state; a new change in the read cycle wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clear) begin
            chg_flag_q    <= 1'b0;
            supply_flag_q <= 1'b1;
            start         <= 1'b0;
            sel_5v        <= 1'b0;
            ioen          <= 1'b0;
            warm          <= 1'b0;
        end else begin
            chg_flag_q    <= (chg_flag_q & ~rd_clear) | pres_chg;
            supply_flag_q <= supply_flag_q & ~rd_clear;
            warm          <= wr_en & wr_warm & ~warm;
            if (wr_en) begin
                start  <= wr_start;
                sel_5v <= wr_5v;
                ioen   <= wr_ioen;
            end
        end
    end

    // Read-side view of the slot and its pending indication.
    always_comb begin
        status  = {4'b0000, supply_flag_q, 1'b0, chg_flag_q, pres_lvl};
        pending = chg_flag_q | supply_flag_q;
    end
endmodule

// File: rtl/card_slot_ctrl.sv
`timescale 1ns/1ps
// Banked status controller for several card slots behind a byte-wide slave
// bus. Decodes select, port and summary addresses, routes the port to the
// general bank or to one slot, drives the active-low interrupt and handles
// shutdown with a timed internal reset on wake. Assumes NUM_SLOTS <= 8 and
// WAKE_CYCLES >= 1.
module card_slot_ctrl #(
    parameter int unsigned NUM_SLOTS   = 5,
    parameter int unsigned WAKE_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_strap,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    input  logic                 bus_rd,
    output logic [7:0]           bus_rdata,
    output logic                 bus_ack,
    input  logic [NUM_SLOTS-1:0] card_present,
    input  logic                 aux_irq_n,
    input  logic                 shutdown_n,
    output logic                 irq_n,
    output logic [NUM_SLOTS-1:0] slot_start,
    output logic [NUM_SLOTS-1:0] slot_5v,
    output logic [NUM_SLOTS-1:0] slot_ioen,
    output logic [NUM_SLOTS-1:0] slot_warm
);
    import card_slot_pkg::*;

    localparam int unsigned WAKE_W = $clog2(WAKE_CYCLES + 1);

    logic [7:0]           sel_q;
    logic                 sdn_q;
    logic [WAKE_W-1:0]    wake_cnt_q;
    logic                 wake_busy;
    logic                 bus_live;
    logic                 hit_sel, hit_port, hit_sum;
    logic                 access;
    logic [7:0]           strap_ofs;
    logic [7:0]           rd_mux;
    logic [NUM_SLOTS-1:0] pres_lvl, pres_chg;
    logic [NUM_SLOTS-1:0] slot_pend;
    logic [NUM_SLOTS-1:0] slot_wr, slot_rd;
    logic [7:0]           slot_stat [NUM_SLOTS];

    // Address decode, bus gating and per-slot strobes.
    always_comb begin
        strap_ofs = addr_strap ? STRAP_OFFSET : 8'h00;
        hit_sel   = bus_addr == (SEL_ADDR | strap_ofs);
        hit_port  = bus_addr == (PORT_ADDR | strap_ofs);
        hit_sum   = bus_addr == (SUMMARY_ADDR | strap_ofs);
        wake_busy = wake_cnt_q != '0;
        bus_live  = shutdown_n & sdn_q & ~wake_busy;
        access    = bus_live & (bus_rd | bus_wr) & (hit_sel | hit_port | hit_sum);
        for (int i = 0; i < NUM_SLOTS; i++) begin
            slot_wr[i] = bus_live & bus_wr & hit_port & (sel_q == 8'(i + 1));
            slot_rd[i] = bus_live & bus_rd & hit_port & (sel_q == 8'(i + 1));
        end
    end

    // Read data multiplexer over select, general bank and slot banks.
    always_comb begin
        rd_mux = 8'h00;
        if (hit_sel) begin
            rd_mux = sel_q;
        end else if (hit_port) begin
            if (sel_q == 8'h00) rd_mux = VERSION_BYTE;
            for (int i = 0; i < NUM_SLOTS; i++)
                if (sel_q == 8'(i + 1)) rd_mux = slot_stat[i];
        end else if (hit_sum && sel_q == 8'h00) begin
            rd_mux = 8'(slot_pend);
        end
    end

    // Shutdown edge tracking and wake-up internal reset counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdn_q      <= 1'b1;
            wake_cnt_q <= '0;
        end else begin
            sdn_q <= shutdown_n;
            if (shutdown_n && !sdn_q)
                wake_cnt_q <= WAKE_W'(WAKE_CYCLES);
            else if (wake_busy)
                wake_cnt_q <= wake_cnt_q - 1'b1;
        end
    end

    // Bank select register.
    always_ff @(posedge clk) begin
        if (!rst_n || wake_busy)
            sel_q <= 8'h00;
        else if (bus_live && bus_wr && hit_sel)
            sel_q <= bus_wdata;
    end

    // Registered acknowledge and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= 8'h00;
        end else begin
            bus_ack   <= access;
            bus_rdata <= (access && bus_rd) ? rd_mux : 8'h00;
        end
    end

    // Interrupt line: released during reset and the wake window.
    always_ff @(posedge clk) begin
        if (!rst_n || wake_busy)
            irq_n <= 1'b1;
        else
            irq_n <= ~((|slot_pend) | ~aux_irq_n);
    end

    slot_presence_sync #(.NUM_SLOTS(NUM_SLOTS)) sync_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_present (card_present),
        .present_lvl (pres_lvl),
        .present_chg (pres_chg)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        slot_status_reg slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_clear (wake_busy),
            .pres_lvl   (pres_lvl[g]),
            .pres_chg   (pres_chg[g]),
            .wr_en      (slot_wr[g]),
            .wr_start   (bus_wdata[CTL_START]),
            .wr_warm    (bus_wdata[CTL_WARM]),
            .wr_5v      (bus_wdata[CTL_5V]),
            .wr_ioen    (bus_wdata[CTL_IOEN]),
            .rd_clear   (slot_rd[g]),
            .status     (slot_stat[g]),
            .pending    (slot_pend[g]),
            .start      (slot_start[g]),
            .sel_5v     (slot_5v[g]),
            .ioen       (slot_ioen[g]),
            .warm       (slot_warm[g])
        );
    end
endmodule

// File: rtl/card_slot_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to card_slot_ctrl; observes ports only.
module card_slot_ctrl_chk #(
    parameter int unsigned NUM_SLOTS = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shutdown_n,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic                 bus_ack,
    input logic                 irq_n,
    input logic [NUM_SLOTS-1:0] slot_warm
);
    // R1: an acknowledge is always preceded by a strobe.
    assert_ack_follows_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_rd || bus_wr));

    // R4: all supply flags pending right after reset pull the line low.
    assert_pending_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> !irq_n);

    // R8: a warm pulse never lasts two cycles.
    assert_warm_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_warm) |=> ((slot_warm & $past(slot_warm)) == '0));

    // R10: no acknowledge for an access made in shutdown.
    assert_no_ack_in_shutdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown_n |=> !bus_ack);

    // R11: the interrupt line is released during the wake reset.
    assert_irq_high_on_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_n) |=> ##1 irq_n);
endmodule

bind card_slot_ctrl card_slot_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shutdown_n (shutdown_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_ack    (bus_ack),
    .irq_n      (irq_n),
    .slot_warm  (slot_warm)
);

// File: tb/card_slot_ctrl_tb_top.sv
`timescale 1ns/1ps
module card_slot_ctrl_tb_top;
    localparam int unsigned NS   = 5;
    localparam int unsigned WAKE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_strap = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic          bus_ack;
    logic [NS-1:0] card_present = '0;
    logic          aux_irq_n = 1'b1;
    logic          shutdown_n = 1'b1;
    logic          irq_n;
    logic [NS-1:0] slot_start, slot_5v, slot_ioen, slot_warm;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic       exp_ack;
        logic [7:0] exp_data;
        bit         chk_data;
        int         due;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    card_slot_ctrl #(.NUM_SLOTS(NS), .WAKE_CYCLES(WAKE)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .card_present(card_present),
        .aux_irq_n(aux_irq_n), .shutdown_n(shutdown_n), .irq_n(irq_n),
        .slot_start(slot_start), .slot_5v(slot_5v), .slot_ioen(slot_ioen),
        .slot_warm(slot_warm)
    );

    task automatic check_val(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Driver: one access, expectation pushed to the scoreboard.
    task automatic access(input bit is_wr, input logic [7:0] addr, input logic [7:0] data,
                          input logic exp_ack, input logic [7:0] exp_data, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr  = addr;
        bus_wr    = is_wr;
        bus_rd    = ~is_wr;
        bus_wdata = data;
        it.exp_ack  = exp_ack;
        it.exp_data = exp_data;
        it.chk_data = ~is_wr & exp_ack;
        it.due      = cyc + 1;
        it.tag      = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
        access(1'b0, addr, 8'h00, 1'b1, exp, tag);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data, input string tag);
        access(1'b1, addr, data, 1'b1, 8'h00, tag);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares bus results in the cycle each expectation falls due.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
                exp_t it;
                it = exp_q.pop_front();
                check_val({it.tag, " ack"}, {7'b0, bus_ack}, {7'b0, it.exp_ack});
                if (it.chk_data) check_val({it.tag, " data"}, bus_rdata, it.exp_data);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        check_val("R9 irq_n in reset", {7'b0, irq_n}, 8'h01);
        check_val("R1 ack in reset", {7'b0, bus_ack}, 8'h00);
        rst_n = 1'b1;
        wait_cyc(2);
        check_val("R4 irq_n after reset", {7'b0, irq_n}, 8'h00);

        wr(8'h48, 8'h00, "R2 select general");
        rd(8'h48, 8'h00, "R2 select readback");
        rd(8'h40, 8'hC1, "R3 version byte");
        rd(8'h42, 8'h1F, "R4 summary after reset");
        rd(8'h50, 8'h00, "R1 stray address");
        exp_q[$].exp_ack = 1'b0;
        exp_q[$].chk_data = 1'b0;

        wr(8'h48, 8'h01, "R2 select slot1");
        rd(8'h48, 8'h01, "R2 select readback slot1");
        rd(8'h40, 8'h08, "R5 supply flag slot1");
        rd(8'h40, 8'h00, "R6 flags cleared slot1");
        wr(8'h48, 8'h00, "R2 select general");
        rd(8'h42, 8'h1E, "R6 other slots keep flags");
        for (int s = 2; s <= 5; s++) begin
            wr(8'h48, 8'(s), "R2 select slot");
            rd(8'h40, 8'h08, "R5 supply flag slot");
        end
        wait_cyc(2);
        check_val("R9 irq_n released", {7'b0, irq_n}, 8'h01);
        wr(8'h48, 8'h00, "R2 select general");
        rd(8'h42, 8'h00, "R4 summary clear");

        card_present[0] = 1'b1;
        wait_cyc(6);
        check_val("R9 irq_n on insert", {7'b0, irq_n}, 8'h00);
        rd(8'h42, 8'h01, "R4 summary slot1 pending");
        wr(8'h48, 8'h01, "R2 select slot1");
        rd(8'h40, 8'h03, "R5 present and changed");
        rd(8'h40, 8'h01, "R6 changed cleared");
        wait_cyc(2);
        check_val("R9 irq_n after clear", {7'b0, irq_n}, 8'h01);

        wr(8'h40, 8'h45, "R7 activate 5V");
        check_val("R7 start", {7'b0, slot_start[0]}, 8'h01);
        check_val("R7 5V", {7'b0, slot_5v[0]}, 8'h01);
        check_val("R7 ioen", {7'b0, slot_ioen[0]}, 8'h01);
        check_val("R8 no warm", {3'b0, slot_warm}, 8'h00);
        wr(8'h40, 8'h47, "R8 warm write");
        check_val("R8 warm pulse", {3'b0, slot_warm}, 8'h01);
        wait_cyc(1);
        check_val("R8 warm ends", {3'b0, slot_warm}, 8'h00);
        wr(8'h40, 8'h05, "R7 drop ioen");
        check_val("R7 ioen dropped", {7'b0, slot_ioen[0]}, 8'h00);
        check_val("R7 still active", {7'b0, slot_start[0]}, 8'h01);
        check_val("R7 still 5V", {7'b0, slot_5v[0]}, 8'h01);
        wr(8'h48, 8'h04, "R2 select slot4");
        wr(8'h40, 8'h41, "R7 activate 3V");
        check_val("R7 slot4 3V", {7'b0, slot_5v[3]}, 8'h00);
        check_val("R7 slot4 start", {7'b0, slot_start[3]}, 8'h01);

        addr_strap = 1'b1;
        rd(8'h4C, 8'h04, "R1 strap select");
        rd(8'h48, 8'h00, "R1 strap old address");
        exp_q[$].exp_ack = 1'b0;
        exp_q[$].chk_data = 1'b0;
        addr_strap = 1'b0;

        aux_irq_n = 1'b0;
        wait_cyc(2);
        check_val("R9 aux irq", {7'b0, irq_n}, 8'h00);
        aux_irq_n = 1'b1;
        wait_cyc(2);
        check_val("R9 aux released", {7'b0, irq_n}, 8'h01);

        shutdown_n = 1'b0;
        wait_cyc(1);
        rd(8'h48, 8'h00, "R10 shutdown no ack");
        exp_q[$].exp_ack = 1'b0;
        exp_q[$].chk_data = 1'b0;
        card_present[1] = 1'b1;
        wait_cyc(6);
        check_val("R10 irq on insert in shutdown", {7'b0, irq_n}, 8'h00);
        shutdown_n = 1'b1;
        wait_cyc(2);
        check_val("R11 irq high in wake reset", {7'b0, irq_n}, 8'h01);
        wait_cyc(WAKE + 3);
        check_val("R11 irq low after wake", {7'b0, irq_n}, 8'h00);
        check_val("R11 controls cleared", {3'b0, slot_start}, 8'h00);
        rd(8'h48, 8'h00, "R11 select restored");
        rd(8'h42, 8'h1F, "R11 summary restored");
        wr(8'h48, 8'h02, "R2 select slot2");
        rd(8'h40, 8'h09, "R11 slot2 present and supply");

        wait_cyc(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule